// File: doc/BRIEF.md
# Vendor Control Register Bank for a USB Transceiver

This block holds two small byte-wide vendor control registers of a USB transceiver that is managed over a register port. The first register is the UART routing register. It holds two enables: one routes the receive path from the data-plus pin to data line 1, and one routes the transmit path from data line 0 to the data-minus pin. The second register is the power register. It holds the data-plus weak pull-up enable and two enables for event reports on the edges of the B-session-valid input.

Each register has three consecutive addresses. A write to the first address replaces the register. A write to the second sets every bit that is 1 in the data. A write to the third clears every bit that is 1 in the data. A read from any of the three addresses returns the register. The routing enables clear themselves when the link leaves UART mode. An enabled edge of the synchronized session-valid input raises a status-command request that carries the alternate-interrupt flag. The request stays raised until the link acknowledges it.

Top module: `ulpi_vctl_bank`

## Requirements
- R1: After reset, both registers read 00h, and rxd_route_en, txd_route_en, dp_pullup_en, evt_req and evt_alt_int are all 0.
- R2: The routing register reads at 19h, 1Ah and 1Bh. A write to 19h loads the data, a write to 1Ah ORs the data in, and a write to 1Bh clears the bits that are 1 in the data. reg_rdata shows the addressed register one cycle after reg_addr is presented.
- R3: The power register behaves the same way at 3Dh (load), 3Eh (set) and 3Fh (clear), and reads at all three addresses.
- R4: Only bits 3 and 2 of the routing register and bits 4, 3 and 2 of the power register can be stored. Every other bit ignores writes and reads as 0.
- R5: rxd_route_en follows bit 3 and txd_route_en follows bit 2 of the routing register. Both outputs change on the same edge that performs the write.
- R6: On the edge where uart_mode is first seen low after being high, bits 3 and 2 of the routing register are cleared. This clear wins over a write to the routing register in the same cycle. The power register is not affected.
- R7: One cycle after the inputs are sampled, dp_pullup_en equals uart_mode OR (power bit 4 AND vbus_sess_ok).
- R8: When power bit 2 is set, a low-to-high change of bvalid_in raises evt_req three clock edges later. When power bit 3 is set, a high-to-low change does the same. evt_alt_int is 1 whenever evt_req is 1.
- R9: evt_req stays 1 until the cycle in which evt_ack is 1. An edge whose enable bit is 0 raises no request.
- R10: Reads from any address outside 19h–1Bh and 3Dh–3Fh return 00h. Writes to those addresses change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rdata | output | 8 | Registered read data |
| uart_mode | input | 1 | Transceiver is in UART mode |
| vbus_sess_ok | input | 1 | VBUS above the A-session-valid threshold |
| bvalid_in | input | 1 | Asynchronous B-session-valid level |
| evt_ack | input | 1 | Link accepts the pending status request |
| rxd_route_en | output | 1 | Route UART receive path |
| txd_route_en | output | 1 | Route UART transmit path |
| dp_pullup_en | output | 1 | Data-plus weak pull-up enable |
| evt_req | output | 1 | Status-command request pending |
| evt_alt_int | output | 1 | Alternate-interrupt flag of the request |

## Verification
Two functions can act on the routing register in the same cycle: the automatic clear on leaving UART mode and a link write to that register. The bench provokes this by lowering uart_mode in the cycle in which it writes 0Ch to 19h. Both routing outputs must then be 0 and the register must read 00h, while the power register keeps its value. In the same way, an enabled session-valid edge can arrive in the cycle of an acknowledge. The bench confirms that the new request survives the acknowledge.

// File: rtl/vctl_pkg.sv
package vctl_pkg;
  localparam int AW   = 6;
  localparam int DW   = 8;
  localparam int NREG = 2;

  // register slots
  localparam int ROUTE_IDX = 0;
  localparam int POWER_IDX = 1;

  localparam logic [AW-1:0] REG_BASE [NREG] = '{6'h19, 6'h3D};
  localparam logic [DW-1:0] REG_MASK [NREG] = '{8'h0C, 8'h1C};

  // bit positions
  localparam int RXD_BIT  = 3;
  localparam int TXD_BIT  = 2;
  localparam int PU_BIT   = 4;
  localparam int FALL_BIT = 3;
  localparam int RISE_BIT = 2;

  localparam logic [DW-1:0] UART_CLR_MASK = (DW'(1) << RXD_BIT) | (DW'(1) << TXD_BIT);

  typedef enum logic [1:0] {OP_LOAD = 2'd0, OP_SET = 2'd1, OP_CLR = 2'd2, OP_NONE = 2'd3} wr_op_e;
endpackage

// File: rtl/vctl_alias_reg.sv
module vctl_alias_reg
  import vctl_pkg::*;
#(
  parameter logic [AW-1:0] BASE = '0,
  parameter logic [DW-1:0] MASK = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr,
  input  logic [DW-1:0] auto_clr,
  output logic          hit,
  output logic [DW-1:0] q
);
  localparam logic [AW-1:0] LAST = BASE + AW'(2);

  wr_op_e          op;
  logic [DW-1:0]   nxt;
  logic [AW-1:0]   offs;

  assign hit  = (addr >= BASE) && (addr <= LAST);
  assign offs = addr - BASE;

  always_comb begin
    op = OP_NONE;
    if (wr && hit) begin
      case (offs[1:0])
        2'd0:    op = OP_LOAD;
        2'd1:    op = OP_SET;
        2'd2:    op = OP_CLR;
        default: op = OP_NONE;
      endcase
    end
  end

  always_comb begin
    case (op)
      OP_LOAD: nxt = wdata;
      OP_SET:  nxt = q | wdata;
      OP_CLR:  nxt = q & ~wdata;
      default: nxt = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt & MASK & ~auto_clr;
  end
endmodule

// File: rtl/vctl_bvalid_evt.sv
module vctl_bvalid_evt #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bvalid_async,
  input  logic rise_en,
  input  logic fall_en,
  input  logic ack,
  output logic req,
  output logic alt
);
  logic [SYNC_STAGES:0] sh;
  logic sync_now, sync_prev, hit_evt;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SYNC_STAGES-1:0], bvalid_async};
  end

  assign sync_now  = sh[SYNC_STAGES-1];
  assign sync_prev = sh[SYNC_STAGES];
  assign hit_evt   = (rise_en && sync_now && !sync_prev) ||
                     (fall_en && !sync_now && sync_prev);

  always_ff @(posedge clk) begin
    if (rst) begin
      req <= 1'b0;
      alt <= 1'b0;
    end else if (hit_evt) begin
      req <= 1'b1;
      alt <= 1'b1;
    end else if (ack) begin
      req <= 1'b0;
      alt <= 1'b0;
    end
  end
endmodule

// File: rtl/ulpi_vctl_bank.sv
module ulpi_vctl_bank
  import vctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          reg_wr,
  output logic [DW-1:0] reg_rdata,
  input  logic          uart_mode,
  input  logic          vbus_sess_ok,
  input  logic          bvalid_in,
  input  logic          evt_ack,
  output logic          rxd_route_en,
  output logic          txd_route_en,
  output logic          dp_pullup_en,
  output logic          evt_req,
  output logic          evt_alt_int
);
  logic [DW-1:0] q   [NREG];
  logic [NREG-1:0] hit;
  logic uart_q, uart_exit;
  logic [DW-1:0] rd_nxt;

  assign uart_exit = uart_q && !uart_mode;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DW-1:0] clr;
    if (i == ROUTE_IDX) begin : g_route
      assign clr = uart_exit ? UART_CLR_MASK : '0;
    end else begin : g_plain
      assign clr = '0;
    end
    vctl_alias_reg #(.BASE(REG_BASE[i]), .MASK(REG_MASK[i])) u_reg (
      .clk(clk), .rst(rst), .addr(reg_addr), .wdata(reg_wdata), .wr(reg_wr),
      .auto_clr(clr), .hit(hit[i]), .q(q[i])
    );
  end

  always_comb begin
    rd_nxt = '0;
    for (int i = 0; i < NREG; i++)
      if (hit[i]) rd_nxt = rd_nxt | q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata    <= '0;
      uart_q       <= 1'b0;
      dp_pullup_en <= 1'b0;
    end else begin
      reg_rdata    <= rd_nxt;
      uart_q       <= uart_mode;
      dp_pullup_en <= uart_mode || (q[POWER_IDX][PU_BIT] && vbus_sess_ok);
    end
  end

  assign rxd_route_en = q[ROUTE_IDX][RXD_BIT];
  assign txd_route_en = q[ROUTE_IDX][TXD_BIT];

  vctl_bvalid_evt #(.SYNC_STAGES(SYNC_STAGES)) u_evt (
    .clk(clk), .rst(rst), .bvalid_async(bvalid_in),
    .rise_en(q[POWER_IDX][RISE_BIT]), .fall_en(q[POWER_IDX][FALL_BIT]),
    .ack(evt_ack), .req(evt_req), .alt(evt_alt_int)
  );
endmodule

// File: rtl/vctl_checker.sv
module vctl_checker
  import vctl_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_rdata,
  input logic          uart_mode,
  input logic          evt_ack,
  input logic          rxd_route_en,
  input logic          txd_route_en,
  input logic          dp_pullup_en,
  input logic          evt_req,
  input logic          evt_alt_int
);
  logic mapped;
  assign mapped = (reg_addr >= 6'h19 && reg_addr <= 6'h1B) ||
                  (reg_addr >= 6'h3D && reg_addr <= 6'h3F);

  // R4: reserved positions never show up on the read port
  p_rsvd_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[7:5] == 3'b000) && (reg_rdata[1:0] == 2'b00));

  // R6: leaving UART mode drops both routing enables
  p_uart_exit_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(uart_mode) |=> (!rxd_route_en && !txd_route_en));

  // R7: UART mode forces the pull-up
  p_pullup_uart_r7: assert property (@(posedge clk) disable iff (rst)
    uart_mode |=> dp_pullup_en);

  // R8: flag accompanies every request
  p_alt_flag_r8: assert property (@(posedge clk) disable iff (rst)
    evt_req |-> evt_alt_int);

  // R9: request held until acknowledged
  p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (evt_req && !evt_ack) |=> evt_req);

  // R10: unmapped reads return zero
  p_unmapped_r10: assert property (@(posedge clk) disable iff (rst)
    !mapped |=> (reg_rdata == 8'h00));
endmodule

bind ulpi_vctl_bank vctl_checker u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .uart_mode(uart_mode), .evt_ack(evt_ack), .rxd_route_en(rxd_route_en),
  .txd_route_en(txd_route_en), .dp_pullup_en(dp_pullup_en),
  .evt_req(evt_req), .evt_alt_int(evt_alt_int)
);

// File: tb/ulpi_vctl_bank_test.sv
module ulpi_vctl_bank_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_rdata;
  logic       uart_mode = 1'b0, vbus_sess_ok = 1'b0, bvalid_in = 1'b0, evt_ack = 1'b0;
  logic       rxd_route_en, txd_route_en, dp_pullup_en, evt_req, evt_alt_int;

  int tests = 0, fails = 0;
  logic [7:0] ma = 8'h00, mb = 8'h00;

  always #5 clk = ~clk;

  ulpi_vctl_bank uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
    .reg_rdata(reg_rdata), .uart_mode(uart_mode), .vbus_sess_ok(vbus_sess_ok),
    .bvalid_in(bvalid_in), .evt_ack(evt_ack), .rxd_route_en(rxd_route_en),
    .txd_route_en(txd_route_en), .dp_pullup_en(dp_pullup_en),
    .evt_req(evt_req), .evt_alt_int(evt_alt_int)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  function automatic logic [7:0] apply(input logic [7:0] cur, input int op,
                                       input logic [7:0] d, input logic [7:0] msk);
    logic [7:0] n;
    n = (op == 0) ? d : (op == 1) ? (cur | d) : (cur & ~d);
    return n & msk;
  endfunction

  function automatic bit mapped(input int a);
    return (a >= 'h19 && a <= 'h1B) || (a >= 'h3D && a <= 'h3F);
  endfunction

  initial begin
    #1ms;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(6'h19, r); check("R1 route reg", r, 8'h00);
    rd(6'h3D, r); check("R1 power reg", r, 8'h00);
    check("R1 outputs", {3'b0, rxd_route_en, txd_route_en, dp_pullup_en, evt_req, evt_alt_int}, 8'h00);

    // R2/R3/R4/R5 sweep over all data values and all aliases
    for (int d = 0; d < 256; d++) begin
      for (int op = 0; op < 3; op++) begin
        wr(6'h19 + 6'(op), 8'(d));
        ma = apply(ma, op, 8'(d), 8'h0C);
        check("R5 routing outputs", {6'b0, rxd_route_en, txd_route_en}, {6'b0, ma[3], ma[2]});
        rd(6'h19 + 6'((d + op) % 3), r); check("R2 R4 route reg", r, ma);
        wr(6'h3D + 6'(op), 8'(d ^ 8'h5A));
        mb = apply(mb, op, 8'(d ^ 8'h5A), 8'h1C);
        rd(6'h3D + 6'((d + op + 1) % 3), r); check("R3 R4 power reg", r, mb);
      end
    end

    // R10 unmapped addresses
    wr(6'h19, 8'h08); ma = 8'h08;
    wr(6'h3D, 8'h00); mb = 8'h00;
    for (int a = 0; a < 64; a++) begin
      if (!mapped(a)) begin
        wr(6'(a), 8'hFF);
        rd(6'(a), r); check("R10 unmapped read", r, 8'h00);
      end
    end
    rd(6'h1A, r); check("R10 route untouched", r, ma);
    rd(6'h3E, r); check("R10 power untouched", r, mb);

    // R7 pull-up truth table
    for (int c = 0; c < 8; c++) begin
      wr(6'h3D, c[0] ? 8'h10 : 8'h00);
      @(negedge clk); uart_mode = c[1]; vbus_sess_ok = c[2];
      @(negedge clk);
      check("R7 pull-up", {7'b0, dp_pullup_en}, {7'b0, c[1] | (c[0] & c[2])});
    end
    @(negedge clk); uart_mode = 1'b0; vbus_sess_ok = 1'b0;
    @(negedge clk);

    // R6 UART exit colliding with a write
    wr(6'h3D, 8'h10); mb = 8'h10;
    @(negedge clk); uart_mode = 1'b1;
    wr(6'h19, 8'h0C);
    check("R6 routing set in UART", {6'b0, rxd_route_en, txd_route_en}, 8'h03);
    @(negedge clk); uart_mode = 1'b0; reg_addr = 6'h19; reg_wdata = 8'h0C; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    check("R6 exit wins over write", {6'b0, rxd_route_en, txd_route_en}, 8'h00);
    rd(6'h19, r); check("R6 route reg cleared", r, 8'h00);
    rd(6'h3D, r); check("R6 power kept", r, mb);

    // R8/R9 events
    wr(6'h3D, 8'h04);
    @(negedge clk); bvalid_in = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R8 rise not yet", {7'b0, evt_req}, 8'h00);
    @(negedge clk);
    check("R8 rise request", {6'b0, evt_req, evt_alt_int}, 8'h03);
    repeat (4) @(negedge clk);
    check("R9 request held", {7'b0, evt_req}, 8'h01);
    evt_ack = 1'b1; @(negedge clk); evt_ack = 1'b0;
    check("R9 request acked", {6'b0, evt_req, evt_alt_int}, 8'h00);
    bvalid_in = 1'b0;
    repeat (6) @(negedge clk);
    check("R9 disabled fall ignored", {7'b0, evt_req}, 8'h00);
    wr(6'h3D, 8'h08);
    bvalid_in = 1'b1;
    repeat (6) @(negedge clk);
    check("R9 disabled rise ignored", {7'b0, evt_req}, 8'h00);
    bvalid_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 fall request", {6'b0, evt_req, evt_alt_int}, 8'h03);
    evt_ack = 1'b1; @(negedge clk); evt_ack = 1'b0;
    // new edge in the ack cycle survives
    wr(6'h3D, 8'h0C);
    bvalid_in = 1'b1;
    @(negedge clk); @(negedge clk);
    evt_ack = 1'b1;
    @(negedge clk); evt_ack = 1'b0;
    check("R9 edge on ack cycle kept", {7'b0, evt_req}, 8'h01);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule